// File: doc/BRIEF.md
# Byte ALU with Nibble-Zero and Carry Status Flags

This block is the byte-wide arithmetic path of a microprogrammed processor. It takes two operands, a left byte and a right byte. A function select picks one of these results: pass the right operand through, true add, complement add, bitwise OR, or an add whose kind the status register decides. The result drives a result bus. That bus is purely combinational, so a register-to-register move is simply a pass through the ALU.

An 8-bit status register sits beside the ALU and is updated at the clock edge that ends each micro-step. Separate strobes in the control word ask for different updates. One tests the upper nibble of the result for zero. Another tests the lower nibble. A third captures the carry-out of an add. A fourth clears the bit that selects the add mode. A per-bit write port lets the control word load any status bit directly. Bits that no strobe or write touches keep their value.

Top module: `byte_alu_flagged`

## Requirements
- R1: The result bus is combinational: with `fn_sel` = 0 (pass) it equals `r_in` in the same cycle, and codes 5 to 7 behave as pass as well.
- R2: With `fn_sel` = 1 (true add) the result bus equals the low 8 bits of `l_in + r_in + carry_in`.
- R3: With `fn_sel` = 2 (complement add) the result bus equals the low 8 bits of `l_in + ~r_in + carry_in`.
- R4: With `fn_sel` = 4 (undetermined add), status bit 0 picks the add: 0 gives true add, 1 gives complement add.
- R5: With `fn_sel` = 3 the result bus is `l_in | r_in`, so with `l_in` = 0 it equals `r_in`.
- R6: At the clock edge, `hi_zero_chk` loads status bit 4 with 1 if result bits [7:4] are all zero, and with 0 otherwise.
- R7: At the clock edge, `lo_zero_chk` loads status bit 5 with 1 if result bits [3:0] are all zero, and with 0 otherwise.
- R8: At the clock edge, `carry_cap` during an add (codes 1, 2, 4) loads status bit 3 with bit 8 of the 9-bit sum. `carry_cap` with a non-add code leaves bit 3 unchanged.
- R9: At the clock edge, `mode_clr` forces status bit 0 to 0, overriding a direct write of that bit.
- R10: At the clock edge, each bit with `bit_wr_en` set loads the matching bit of `bit_wr_val`. The flag strobes of R6 to R9 take precedence on their own bits.
- R11: Status bits that no strobe or write addresses keep their value. A synchronous `rst` clears all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Micro-step clock |
| rst | input | 1 | Synchronous reset, active high |
| fn_sel | input | 3 | Function code: 0 pass, 1 true add, 2 complement add, 3 OR, 4 add selected by status bit 0 |
| l_in | input | 8 | Left operand |
| r_in | input | 8 | Right operand |
| carry_in | input | 1 | Carry into the adder |
| carry_cap | input | 1 | Capture carry-out into status bit 3 |
| hi_zero_chk | input | 1 | Test upper result nibble into status bit 4 |
| lo_zero_chk | input | 1 | Test lower result nibble into status bit 5 |
| mode_clr | input | 1 | Clear status bit 0 |
| bit_wr_en | input | 8 | Per-bit direct write enables for the status register |
| bit_wr_val | input | 8 | Values for the direct status writes |
| z_bus | output | 8 | Combinational ALU result |
| status | output | 8 | Status register |

## Verification
The result bus carries no register, so it is due in the same cycle as its operands. The bench drives operands at the falling edge and compares the bus one nanosecond later, without waiting for a clock. Every status effect lands on the first rising edge after its strobe is driven. The bench therefore holds each strobe across exactly one rising edge and compares the status register at the next falling edge. Flag values come from a bench model of the result, never from the design's internals. The hold checks compare the whole register after strobes aimed elsewhere, so an unintended write shows up in a bit no strobe addressed.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    typedef enum logic [2:0] {
        FN_PASS     = 3'd0,
        FN_ADD_TRUE = 3'd1,
        FN_ADD_CMPL = 3'd2,
        FN_OR       = 3'd3,
        FN_ADD_AUTO = 3'd4
    } alu_fn_e;

    localparam int ST_W     = 8;
    localparam int ST_MODE  = 0;   // add-kind select for undetermined add
    localparam int ST_CARRY = 3;   // captured carry-out
    localparam int ST_HIZ   = 4;   // upper nibble zero
    localparam int ST_LOZ   = 5;   // lower nibble zero

    typedef struct packed {
        logic [ST_W-1:0] status;
    } alu_state_t;

endpackage

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        fn_sel,
    input  logic [DATA_W-1:0] l_in,
    input  logic [DATA_W-1:0] r_in,
    input  logic              carry_in,
    input  logic              mode_cmpl,
    output logic [DATA_W-1:0] z_out,
    output logic              carry_out,
    output logic              add_op
);
    alu_fn_e           fn;
    logic              cmpl;
    logic [DATA_W-1:0] b_opnd;
    logic [DATA_W:0]   sum;

    always_comb begin
        fn     = alu_fn_e'(fn_sel);
        add_op = 1'b0;
        cmpl   = 1'b0;
        case (fn)
            FN_ADD_TRUE: add_op = 1'b1;
            FN_ADD_CMPL: begin
                add_op = 1'b1;
                cmpl   = 1'b1;
            end
            FN_ADD_AUTO: begin
                add_op = 1'b1;
                cmpl   = mode_cmpl;
            end
            default: ;
        endcase
        b_opnd    = cmpl ? ~r_in : r_in;
        sum       = {1'b0, l_in} + {1'b0, b_opnd} + {{DATA_W{1'b0}}, carry_in};
        carry_out = sum[DATA_W];
        if (add_op)
            z_out = sum[DATA_W-1:0];
        else if (fn == FN_OR)
            z_out = l_in | r_in;
        else
            z_out = r_in;
    end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [ST_W-1:0]   status_q,
    input  logic [DATA_W-1:0] z_in,
    input  logic              carry_out,
    input  logic              add_op,
    input  logic              carry_cap,
    input  logic              hi_zero_chk,
    input  logic              lo_zero_chk,
    input  logic              mode_clr,
    input  logic [ST_W-1:0]   bit_wr_en,
    input  logic [ST_W-1:0]   bit_wr_val,
    output logic [ST_W-1:0]   status_d
);
    localparam int NIB_W = DATA_W / 2;

    logic hi_zero;
    logic lo_zero;

    always_comb begin
        hi_zero  = ~|z_in[DATA_W-1:NIB_W];
        lo_zero  = ~|z_in[NIB_W-1:0];
        status_d = (status_q & ~bit_wr_en) | (bit_wr_val & bit_wr_en);
        if (carry_cap && add_op)
            status_d[ST_CARRY] = carry_out;
        if (hi_zero_chk)
            status_d[ST_HIZ] = hi_zero;
        if (lo_zero_chk)
            status_d[ST_LOZ] = lo_zero;
        if (mode_clr)
            status_d[ST_MODE] = 1'b0;
    end
endmodule

// File: rtl/byte_alu_flagged.sv
module byte_alu_flagged
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        fn_sel,
    input  logic [DATA_W-1:0] l_in,
    input  logic [DATA_W-1:0] r_in,
    input  logic              carry_in,
    input  logic              carry_cap,
    input  logic              hi_zero_chk,
    input  logic              lo_zero_chk,
    input  logic              mode_clr,
    input  logic [ST_W-1:0]   bit_wr_en,
    input  logic [ST_W-1:0]   bit_wr_val,
    output logic [DATA_W-1:0] z_bus,
    output logic [ST_W-1:0]   status
);
    alu_state_t      st_d, st_q;
    logic            cout;
    logic            is_add;
    logic [ST_W-1:0] flags_d;

    byte_alu_core #(.DATA_W(DATA_W)) i_core (
        .fn_sel    (fn_sel),
        .l_in      (l_in),
        .r_in      (r_in),
        .carry_in  (carry_in),
        .mode_cmpl (st_q.status[ST_MODE]),
        .z_out     (z_bus),
        .carry_out (cout),
        .add_op    (is_add)
    );

    byte_alu_flags #(.DATA_W(DATA_W)) i_flags (
        .status_q    (st_q.status),
        .z_in        (z_bus),
        .carry_out   (cout),
        .add_op      (is_add),
        .carry_cap   (carry_cap),
        .hi_zero_chk (hi_zero_chk),
        .lo_zero_chk (lo_zero_chk),
        .mode_clr    (mode_clr),
        .bit_wr_en   (bit_wr_en),
        .bit_wr_val  (bit_wr_val),
        .status_d    (flags_d)
    );

    always_comb begin
        st_d.status = flags_d;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign status = st_q.status;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        fn_sel,
    input logic [DATA_W-1:0] l_in,
    input logic [DATA_W-1:0] r_in,
    input logic              carry_cap,
    input logic              hi_zero_chk,
    input logic              lo_zero_chk,
    input logic              mode_clr,
    input logic [ST_W-1:0]   bit_wr_en,
    input logic [DATA_W-1:0] z_bus,
    input logic [ST_W-1:0]   status
);
    localparam int NIB_W = DATA_W / 2;

    logic add_code;
    assign add_code = (fn_sel == 3'd1) || (fn_sel == 3'd2) || (fn_sel == 3'd4);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (status == '0)); // R11

    AST_OR_WITH_ZERO_L: assert property (@(posedge clk) disable iff (rst)
        (fn_sel == 3'd3 && l_in == '0) |-> (z_bus == r_in)); // R5

    AST_PASS_FOLLOWS_R: assert property (@(posedge clk) disable iff (rst)
        (fn_sel == 3'd0) |-> (z_bus == r_in)); // R1

    AST_HI_NIBBLE_FLAG: assert property (@(posedge clk) disable iff (rst)
        hi_zero_chk |=> (status[ST_HIZ] == ($past(z_bus[DATA_W-1:NIB_W]) == '0))); // R6

    AST_LO_NIBBLE_FLAG: assert property (@(posedge clk) disable iff (rst)
        lo_zero_chk |=> (status[ST_LOZ] == ($past(z_bus[NIB_W-1:0]) == '0))); // R7

    AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!(carry_cap && add_code) && !bit_wr_en[ST_CARRY]) |=> $stable(status[ST_CARRY])); // R8

    AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        mode_clr |=> !status[ST_MODE]); // R9
endmodule

bind byte_alu_flagged byte_alu_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .fn_sel      (fn_sel),
    .l_in        (l_in),
    .r_in        (r_in),
    .carry_cap   (carry_cap),
    .hi_zero_chk (hi_zero_chk),
    .lo_zero_chk (lo_zero_chk),
    .mode_clr    (mode_clr),
    .bit_wr_en   (bit_wr_en),
    .z_bus       (z_bus),
    .status      (status)
);

// File: tb/test_byte_alu_flagged.sv
`timescale 1ns/1ps
module test_byte_alu_flagged;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] fn_sel;
    logic [7:0] l_in, r_in;
    logic       carry_in, carry_cap, hi_zero_chk, lo_zero_chk, mode_clr;
    logic [7:0] bit_wr_en, bit_wr_val;
    logic [7:0] z_bus, status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    byte_alu_flagged i_byte_alu_flagged (
        .clk(clk), .rst(rst), .fn_sel(fn_sel), .l_in(l_in), .r_in(r_in),
        .carry_in(carry_in), .carry_cap(carry_cap), .hi_zero_chk(hi_zero_chk),
        .lo_zero_chk(lo_zero_chk), .mode_clr(mode_clr), .bit_wr_en(bit_wr_en),
        .bit_wr_val(bit_wr_val), .z_bus(z_bus), .status(status)
    );

    // Model of the 9-bit sum per the requirements
    function automatic logic [8:0] model_sum(input logic [2:0] f, input logic [7:0] a,
                                             input logic [7:0] b, input logic c, input logic s0);
        logic cm;
        cm = (f == 3'd2) || (f == 3'd4 && s0);
        return {1'b0, a} + {1'b0, (cm ? ~b : b)} + {8'd0, c};
    endfunction

    function automatic logic [7:0] model_z(input logic [2:0] f, input logic [7:0] a,
                                           input logic [7:0] b, input logic c, input logic s0);
        if (f == 3'd1 || f == 3'd2 || f == 3'd4) return model_sum(f, a, b, c, s0)[7:0];
        if (f == 3'd3) return a | b;
        return b;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        fn_sel = 3'd0; l_in = 8'h00; r_in = 8'h00; carry_in = 1'b0;
        carry_cap = 1'b0; hi_zero_chk = 1'b0; lo_zero_chk = 1'b0; mode_clr = 1'b0;
        bit_wr_en = 8'h00; bit_wr_val = 8'h00;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_status(input logic [7:0] v);
        idle();
        bit_wr_en = 8'hFF; bit_wr_val = v;
        step();
        idle();
    endtask

    task automatic comb_z(input string req, input logic [2:0] f, input logic [7:0] a,
                          input logic [7:0] b, input logic c);
        fn_sel = f; l_in = a; r_in = b; carry_in = c;
        #1;
        check(req, z_bus, model_z(f, a, b, c, status[0]));
    endtask

    task automatic t_reset();
        idle();
        rst = 1'b1;
        step(); step();
        check("R11 reset", status, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_pass();
        comb_z("R1 pass", 3'd0, 8'h5A, 8'h1A, 1'b1);
        comb_z("R1 code5", 3'd5, 8'hFF, 8'h3C, 1'b0);
        comb_z("R1 code7", 3'd7, 8'h81, 8'hC3, 1'b1);
        idle();
    endtask

    task automatic t_true_add();
        comb_z("R2 add", 3'd1, 8'h12, 8'h34, 1'b0);
        comb_z("R2 add wrap", 3'd1, 8'hF0, 8'h20, 1'b1);
        idle();
    endtask

    task automatic t_cmpl_add();
        comb_z("R3 cmpl equal", 3'd2, 8'h1A, 8'h1A, 1'b1);
        comb_z("R3 cmpl borrow", 3'd2, 8'h10, 8'h20, 1'b1);
        idle();
    endtask

    task automatic t_auto_add();
        write_status(8'h00);
        comb_z("R4 auto true", 3'd4, 8'h30, 8'h05, 1'b0);
        check("R4 auto true value", z_bus, 8'h35);
        write_status(8'h01);
        comb_z("R4 auto cmpl", 3'd4, 8'h30, 8'h05, 1'b1);
        check("R4 auto cmpl value", z_bus, 8'h2B);
        write_status(8'h00);
    endtask

    task automatic t_or();
        comb_z("R5 or", 3'd3, 8'hA0, 8'h05, 1'b0);
        comb_z("R5 or zero l", 3'd3, 8'h00, 8'h75, 1'b0);
        idle();
    endtask

    task automatic t_nibbles();
        write_status(8'h00);
        fn_sel = 3'd0; r_in = 8'h0A; hi_zero_chk = 1'b1; lo_zero_chk = 1'b1;
        step();
        check("R6 hi zero set", {7'd0, status[4]}, 8'h01);
        check("R7 lo nonzero", {7'd0, status[5]}, 8'h00);
        fn_sel = 3'd0; r_in = 8'h70; hi_zero_chk = 1'b1; lo_zero_chk = 1'b1;
        step();
        check("R6 hi nonzero", {7'd0, status[4]}, 8'h00);
        check("R7 lo zero set", {7'd0, status[5]}, 8'h01);
        idle();
    endtask

    task automatic t_carry();
        logic [8:0] s;
        write_status(8'h00);
        fn_sel = 3'd1; l_in = 8'hF0; r_in = 8'h20; carry_in = 1'b0; carry_cap = 1'b1;
        s = model_sum(3'd1, 8'hF0, 8'h20, 1'b0, 1'b0);
        step();
        check("R8 carry set", {7'd0, status[3]}, {7'd0, s[8]});
        fn_sel = 3'd3; l_in = 8'h00; r_in = 8'h00; carry_cap = 1'b1;
        step();
        check("R8 non-add ignored", status, 8'h08);
        fn_sel = 3'd1; l_in = 8'h01; r_in = 8'h02; carry_cap = 1'b0;
        step();
        check("R8 no cap holds", status, 8'h08);
        fn_sel = 3'd2; l_in = 8'h10; r_in = 8'h20; carry_in = 1'b1; carry_cap = 1'b1;
        step();
        check("R8 cmpl no carry", status, 8'h00);
        idle();
    endtask

    task automatic t_mode_clr();
        write_status(8'h01);
        mode_clr = 1'b1; bit_wr_en = 8'h01; bit_wr_val = 8'h01;
        step();
        check("R9 clear wins", status, 8'h00);
        idle();
    endtask

    task automatic t_bit_write();
        write_status(8'h00);
        bit_wr_en = 8'hC6; bit_wr_val = 8'hFF;
        step();
        check("R10 direct write", status, 8'hC6);
        bit_wr_en = 8'h10; bit_wr_val = 8'h10; fn_sel = 3'd0; r_in = 8'h80; hi_zero_chk = 1'b1;
        step();
        check("R10 strobe precedence", status, 8'hC6);
        idle();
    endtask

    task automatic t_hold();
        write_status(8'hA5);
        fn_sel = 3'd1; l_in = 8'h11; r_in = 8'h22; carry_in = 1'b1;
        step();
        check("R11 hold idle", status, 8'hA5);
        lo_zero_chk = 1'b1; fn_sel = 3'd0; r_in = 8'h00;
        step();
        check("R11 hold others", status, 8'hA5);
        idle();
    endtask

    initial begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_true_add();
        t_cmpl_add();
        t_auto_add();
        t_or();
        t_nibbles();
        t_carry();
        t_mode_clr();
        t_bit_write();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule